// File: doc/BRIEF.md
# Full-Page Read Burst Engine

This block is the read side of one bank of a 16-bit synchronous DRAM-style memory, seen from inside the device. It takes decoded commands from the command decoder: activate, read, burst stop and precharge, one per clock at most. A read carries an 8-bit start column. The engine then streams one data word per clock onto a data bus. An output-enable flag marks the cycles in which the bus is driven; when the flag is low the bus counts as high impedance. The page holds 256 columns, and its contents come from a fixed pattern computed from the column index.

A burst has no length. It walks the page one column per clock, wraps from the last column back to the first, and runs until a burst stop arrives. The delay from read to first word is the CAS latency, which can be 2 or 3. The delay from stop to high impedance is the same number of clocks, because words already in the read pipeline are still delivered. A second read during a burst restarts the walk at the new column.

The block also times how long a row stays open. It counts clocks from each activate. If no precharge comes within the allowed row-active window, it raises a sticky violation flag.

Top module: `fpage_rd_engine`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, dataOutEn is 0 and rasLateErr is 0.
- R2: The word delivered for column c is {c XOR 8'hC3, c}: bits 15:8 hold the column XOR the seed 8'hC3, and bits 7:0 hold the column.
- R3: If a READ is sampled at clock edge k, the word for startCol is on dataOut with dataOutEn high in the cycle after edge k+CL. CL is 2 when casLat3 is 0 and 3 when casLat3 is 1.
- R4: During a burst, each later cycle delivers the next column. After column 255 comes column 0, and the walk goes on with no limit until a stop.
- R5: If a STOP is sampled at edge s during a burst, the last word delivered is the one for the column reached before edge s. Data keeps flowing for CL cycles after the stop. dataOutEn is 0 from the cycle after edge s+CL onward.
- R6: A STOP sampled while no burst is running has no effect: dataOutEn stays 0.
- R7: A READ sampled during a burst restarts the walk at the new startCol. Words for the old burst issued before that edge are still delivered in order, and the new words follow with no gap.
- R8: Suppose an ACTIVATE is sampled at edge a. A PRECHARGE sampled at edge a+n with 1 <= n <= TRAS_MAX (default 20) leaves rasLateErr at 0. If no PRECHARGE has been sampled by edge a+TRAS_MAX, rasLateErr is 1 from the cycle after that edge.
- R9: Once set, rasLateErr stays 1 until reset, even across later ACTIVATE and PRECHARGE commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdAct | input | 1 | Decoded activate command |
| cmdRead | input | 1 | Decoded read command |
| cmdStop | input | 1 | Decoded burst stop command |
| cmdPre | input | 1 | Decoded precharge command |
| startCol | input | 8 | Start column, used with cmdRead |
| casLat3 | input | 1 | CAS latency select: 0 means 2 clocks, 1 means 3 clocks |
| dataOut | output | 16 | Read data word |
| dataOutEn | output | 1 | Bus driven; low stands for high impedance |
| rasLateErr | output | 1 | Sticky row-active time violation |

## Verification
The properties assume two things about the inputs. First, the command inputs are at most one-hot in every cycle. Second, casLat3 holds still while a burst runs or words are still in the read pipeline. Under these assumptions the read-to-data and stop-to-float delays are fixed numbers of clocks. The stimulus drives only one command per clock. It changes the latency only after the scoreboard queue has drained and several idle clocks have passed, so the latency never changes mid-stream.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int COL_W  = 8;
  localparam int DATA_W = 16;

  typedef logic [COL_W-1:0]  col_t;
  typedef logic [DATA_W-1:0] word_t;

  // strobe from control to datapath: fetch one column this cycle
  typedef struct packed {
    logic issue;
    col_t col;
  } issue_strb_t;
endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl #(
  parameter int TRAS_MAX = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdAct,
  input  logic                cmdRead,
  input  logic                cmdStop,
  input  logic                cmdPre,
  input  fpr_pkg::col_t       startCol,
  output fpr_pkg::issue_strb_t strb,
  output logic                rowOpen,
  output logic                rasLateErr
);
  import fpr_pkg::*;

  localparam int AGE_W = (TRAS_MAX > 2) ? $clog2(TRAS_MAX) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TRAS_MAX - 1);

  logic burstOn;
  col_t colPtr;
  logic [AGE_W-1:0] rowAge;

  // a read starts (or restarts) the walk; a stop ends it at this edge
  always_comb begin
    strb.issue = cmdRead | (burstOn & ~cmdStop);
    strb.col   = cmdRead ? startCol : colPtr;
  end

  // column walk: 8-bit counter, overflow gives the page wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      colPtr  <= '0;
    end else begin
      burstOn <= strb.issue;
      if (strb.issue) colPtr <= col_t'(strb.col + 1'b1);
    end
  end

  // row-active window timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOpen    <= 1'b0;
      rowAge     <= '0;
      rasLateErr <= 1'b0;
    end else if (cmdAct) begin
      rowOpen <= 1'b1;
      rowAge  <= '0;
    end else if (rowOpen) begin
      if (cmdPre) begin
        rowOpen <= 1'b0;
      end else if (rowAge == AGE_LAST) begin
        rasLateErr <= 1'b1;
        rowOpen    <= 1'b0;
      end else begin
        rowAge <= rowAge + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpr_datapath.sv
module fpr_datapath #(
  parameter fpr_pkg::col_t SEED  = 8'hC3,
  parameter int            CL_LO = 2,
  parameter int            CL_HI = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpr_pkg::issue_strb_t strb,
  input  logic                 casLat3,
  output fpr_pkg::word_t       dataOut,
  output logic                 dataOutEn
);
  import fpr_pkg::*;

  localparam int DEPTH = CL_HI + 1;

  // page contents are a fixed pattern of the column index
  function automatic word_t pageWord(input col_t c);
    return {c ^ SEED, c};
  endfunction

  logic [DEPTH-1:0] vld;
  word_t            dat [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld[0] <= 1'b0;
      dat[0] <= '0;
    end else begin
      vld[0] <= strb.issue;
      dat[0] <= strb.issue ? pageWord(strb.col) : '0;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[g] <= 1'b0;
        dat[g] <= '0;
      end else begin
        vld[g] <= vld[g-1];
        dat[g] <= dat[g-1];
      end
    end
  end

  // latency selects the tap; in-flight words drain after a stop
  always_comb begin
    if (casLat3) begin
      dataOutEn = vld[CL_HI];
      dataOut   = vld[CL_HI] ? dat[CL_HI] : '0;
    end else begin
      dataOutEn = vld[CL_LO];
      dataOut   = vld[CL_LO] ? dat[CL_LO] : '0;
    end
  end
endmodule

// File: rtl/fpage_rd_engine.sv
module fpage_rd_engine #(
  parameter int            TRAS_MAX = 20,
  parameter fpr_pkg::col_t SEED     = 8'hC3,
  parameter int            CL_LO    = 2,
  parameter int            CL_HI    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdAct,
  input  logic        cmdRead,
  input  logic        cmdStop,
  input  logic        cmdPre,
  input  logic [7:0]  startCol,
  input  logic        casLat3,
  output logic [15:0] dataOut,
  output logic        dataOutEn,
  output logic        rasLateErr
);
  import fpr_pkg::*;

  issue_strb_t strb;
  logic        rowOpen;

  fpr_ctrl #(.TRAS_MAX(TRAS_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdStop(cmdStop), .cmdPre(cmdPre),
    .startCol(startCol),
    .strb(strb), .rowOpen(rowOpen), .rasLateErr(rasLateErr)
  );

  fpr_datapath #(.SEED(SEED), .CL_LO(CL_LO), .CL_HI(CL_HI)) dp_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .casLat3(casLat3),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/fpr_chk.sv
module fpr_chk #(
  parameter int CL_LO = 2,
  parameter int CL_HI = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdAct,
  input logic                 cmdRead,
  input logic                 cmdStop,
  input logic                 cmdPre,
  input logic                 casLat3,
  input logic                 dataOutEn,
  input logic                 rasLateErr,
  input fpr_pkg::issue_strb_t strb,
  input logic                 rowOpen
);
  // input-side assumptions
  a_in_cmd_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdAct, cmdRead, cmdStop, cmdPre}));
  a_in_cl_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue || dataOutEn) |=> $stable(casLat3));

  // R3: first word after CL edges
  a_r3_first_cl_lo: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !casLat3) |-> ##(CL_LO+1) dataOutEn);
  a_r3_first_cl_hi: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && casLat3) |-> ##(CL_HI+1) dataOutEn);

  // R4: consecutive columns, wrap by 8-bit overflow
  a_r4_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !cmdRead && $past(strb.issue)) |-> (strb.col == 8'($past(strb.col) + 8'd1)));

  // R5: stop ends issuing; bus enable follows issue by exactly CL
  a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |=> (!strb.issue || cmdRead));
  a_r5_oe_lo: assert property (@(posedge clk) disable iff (!rstN)
    !casLat3 |-> (dataOutEn == $past(strb.issue, CL_LO+1)));
  a_r5_oe_hi: assert property (@(posedge clk) disable iff (!rstN)
    casLat3 |-> (dataOutEn == $past(strb.issue, CL_HI+1)));

  // R8: violation only from an open row with no precharge
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasLateErr) |-> ($past(rowOpen) && !$past(cmdPre) && !$past(cmdAct)));

  // R9: sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(rasLateErr) |-> rasLateErr);
endmodule

bind fpage_rd_engine fpr_chk #(.CL_LO(CL_LO), .CL_HI(CL_HI)) chk_i (
  .clk(clk), .rstN(rstN),
  .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdStop(cmdStop), .cmdPre(cmdPre),
  .casLat3(casLat3), .dataOutEn(dataOutEn), .rasLateErr(rasLateErr),
  .strb(strb), .rowOpen(rowOpen)
);

// File: tb/fpage_rd_engine_tb_top.sv
module fpage_rd_engine_tb_top;
  localparam int TRAS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdAct = 1'b0, cmdRead = 1'b0, cmdStop = 1'b0, cmdPre = 1'b0;
  logic [7:0]  startCol = '0;
  logic        casLat3 = 1'b0;
  logic [15:0] dataOut;
  logic        dataOutEn;
  logic        rasLateErr;

  always #10 clk = ~clk;   // 50 MHz

  fpage_rd_engine #(.TRAS_MAX(TRAS)) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdStop(cmdStop), .cmdPre(cmdPre),
    .startCol(startCol), .casLat3(casLat3),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .rasLateErr(rasLateErr)
  );

  typedef struct { int unsigned cyc; logic [15:0] w; } exp_t;
  exp_t expQ[$];

  int unsigned cyc = 0;
  int total = 0, bad = 0;
  bit monOn = 1'b0, done = 1'b0;
  string curReq = "R1";

  // reference burst state, kept from the requirements
  bit         mLive = 1'b0;
  logic [7:0] mCol  = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] colWord(input logic [7:0] c);   // R2
    return {c ^ 8'hC3, c};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: sets inputs before edge cyc+1 and pushes expected words
  task automatic tick(input bit r, input bit s, input bit a, input bit p,
                      input logic [7:0] col);
    int unsigned eIdx;
    @(negedge clk);
    cmdRead = r; cmdStop = s; cmdAct = a; cmdPre = p; startCol = col;
    eIdx = cyc + 1;
    if (r) begin mLive = 1'b1; mCol = col; end
    else if (s) mLive = 1'b0;
    if (mLive) begin
      expQ.push_back('{eIdx + (casLat3 ? 3 : 2), colWord(mCol)});
      mCol = mCol + 8'd1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic drain();
    while (expQ.size() > 0) idle(1);
    idle(3);
  endtask

  // monitor: scoreboard comparison every cycle
  always @(negedge clk) begin
    if (monOn) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        check(dataOutEn === 1'b1, curReq, "oe", {31'd0, dataOutEn}, 32'd1);
        check(dataOut === e.w, curReq, "data", {16'd0, dataOut}, {16'd0, e.w});
      end else begin
        check(dataOutEn === 1'b0, curReq, "oe idle", {31'd0, dataOutEn}, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dataOutEn === 1'b0, "R1", "oe in reset", {31'd0, dataOutEn}, 32'd0);
    check(rasLateErr === 1'b0, "R1", "err in reset", {31'd0, rasLateErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(dataOutEn === 1'b0, "R1", "oe after reset", {31'd0, dataOutEn}, 32'd0);
    check(rasLateErr === 1'b0, "R1", "err after reset", {31'd0, rasLateErr}, 32'd0);
    monOn = 1'b1;

    // R2 R3 R5: short burst at CL 2
    curReq = "R3_R5_cl2"; casLat3 = 1'b0;
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'd10);
    idle(5);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    drain();

    // R3 R5: short burst at CL 3
    curReq = "R3_R5_cl3"; casLat3 = 1'b1; idle(3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'h40);
    idle(4);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    drain();

    // R6: stop with no burst
    curReq = "R6";
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    idle(6);

    // R4: wrap across the page end, more than a full page, CL 2
    curReq = "R4_wrap"; casLat3 = 1'b0; idle(3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'd250);
    idle(299);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    drain();

    // R7: restart mid burst, CL 3
    curReq = "R7"; casLat3 = 1'b1; idle(3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'd5);
    idle(3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'h80);
    idle(2);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    drain();

    // R5 with a one-word burst at CL 2 (stop right after read)
    curReq = "R5_single"; casLat3 = 1'b0; idle(3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 8'd255);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    drain();

    // R8: precharge exactly at the window limit
    curReq = "R8";
    tick(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(TRAS - 1);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    idle(3);
    check(rasLateErr === 1'b0, "R8", "pre on time", {31'd0, rasLateErr}, 32'd0);

    // R8: precharge missing
    tick(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(TRAS);
    check(rasLateErr === 1'b0, "R8", "one clock before limit", {31'd0, rasLateErr}, 32'd0);
    idle(1);
    check(rasLateErr === 1'b1, "R8", "limit passed", {31'd0, rasLateErr}, 32'd1);

    // R9: sticky across new activate and precharge
    tick(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(2);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    idle(2);
    check(rasLateErr === 1'b1, "R9", "sticky", {31'd0, rasLateErr}, 32'd1);

    monOn = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(rasLateErr === 1'b0, "R9", "cleared by reset", {31'd0, rasLateErr}, 32'd0);
    rstN = 1'b1;
    idle(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule